// File: doc/BRIEF.md
# Vector Register Read-Port Allocator

This combinational block sits in the dispatch stage of a vector back end. Each cycle it looks at the source operands of two candidate micro-ops, the older (slot 0) and the younger (slot 1), and places their register indices onto four shared read ports of the vector register file. The file answers within the same cycle. The block then routes the returned words into per-operand slots for each micro-op. The mask register v0 arrives on a dedicated path of its own and is handed to both micro-ops without using a general port.

The port layout is fixed and interleaved. Each micro-op owns one port for its second source (vs2). The first-source (vs1) and destination-as-source (vd) reads of the two micro-ops share ports 1 and 3 crosswise. When both micro-ops want the same shared port, the block raises a structural-hazard flag. The dispatch controller then issues only slot 0, and all ports go to slot 0.

Top module: `vreg_read_alloc`

## Requirements
- R1: With the hazard flag low, slot 0's vs2, vs1 and vd indices appear on ports 0, 1 and 3 whenever their valid bits are set.
- R2: With the hazard flag low, slot 1's vs2, vs1 and vd indices appear on ports 2, 3 and 1 whenever their valid bits are set.
- R3: A port that no valid operand claims drives index 0, and an operand whose valid bit is clear never causes a hazard.
- R4: The hazard flag is high exactly when slot 0 needs vs1 while slot 1 needs vd (port 1), or when slot 0 needs vd while slot 1 needs vs1 (port 3).
- R5: Whenever the two slots together have more than four valid source operands, the hazard flag is high.
- R6: With the hazard flag high, ports 0, 1 and 3 carry slot 0's vs2, vs1 and vd indices (0 where the operand is invalid), and port 2 drives 0.
- R7: Slot 0's operand outputs take the data of ports 0 (vs2), 1 (vs1) and 3 (vd) in the same cycle. An operand whose valid bit is clear outputs all zeros.
- R8: Slot 1's operand outputs take the data of ports 2 (vs2), 3 (vs1) and 1 (vd). They output all zeros when the operand's valid bit is clear or when the hazard flag is high.
- R9: Both slots' mask outputs always equal the dedicated v0 data, whatever the hazard flag and the valid bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| u0_vs2_idx | input | IDX_W | slot 0 second-source register index |
| u0_vs2_vld | input | 1 | slot 0 needs vs2 |
| u0_vs1_idx | input | IDX_W | slot 0 first-source register index |
| u0_vs1_vld | input | 1 | slot 0 needs vs1 |
| u0_vd_idx | input | IDX_W | slot 0 destination-as-source index |
| u0_vd_vld | input | 1 | slot 0 needs the old vd value |
| u1_vs2_idx | input | IDX_W | slot 1 second-source register index |
| u1_vs2_vld | input | 1 | slot 1 needs vs2 |
| u1_vs1_idx | input | IDX_W | slot 1 first-source register index |
| u1_vs1_vld | input | 1 | slot 1 needs vs1 |
| u1_vd_idx | input | IDX_W | slot 1 destination-as-source index |
| u1_vd_vld | input | 1 | slot 1 needs the old vd value |
| rd_idx | output | 4 x IDX_W | read index of each register-file port |
| rd_data | input | 4 x DATA_W | same-cycle data of each port |
| v0_data | input | DATA_W | mask register contents from the dedicated path |
| port_hazard | output | 1 | slots collide on a shared port; issue slot 0 only |
| u0_vs2_opnd | output | DATA_W | slot 0 vs2 operand |
| u0_vs1_opnd | output | DATA_W | slot 0 vs1 operand |
| u0_vd_opnd | output | DATA_W | slot 0 vd operand |
| u0_mask_opnd | output | DATA_W | slot 0 mask operand |
| u1_vs2_opnd | output | DATA_W | slot 1 vs2 operand |
| u1_vs1_opnd | output | DATA_W | slot 1 vs1 operand |
| u1_vd_opnd | output | DATA_W | slot 1 vd operand |
| u1_mask_opnd | output | DATA_W | slot 1 mask operand |

## Verification
The checks assume that the register file returns the data of the presented indices within the same cycle. They do not depend on the register file's contents. The bench therefore drives a distinct fixed word on each port, so any wrong routing shows up as a mismatch. The checks also assume that the six valid bits and the indices are stable once the combinational logic has settled. The bench changes inputs only from tasks and samples one time unit later. It walks all 64 combinations of the valid bits, so every possible pairing on the shared ports is reached.

// File: rtl/vreg_rp_pkg.sv
package vreg_rp_pkg;

  parameter int unsigned RP_IDX_W = 5;
  parameter int unsigned RP_PORTS = 4;
  parameter int unsigned RP_SLOTS = 2;
  parameter int unsigned RP_SRCS  = 3;

  // operand order inside a slot: 0 = vs2, 1 = vs1, 2 = vd
  typedef struct packed {
    logic [RP_IDX_W-1:0] vs2;
    logic                vs2_v;
    logic [RP_IDX_W-1:0] vs1;
    logic                vs1_v;
    logic [RP_IDX_W-1:0] vd;
    logic                vd_v;
  } rp_src_t;

  function automatic logic [RP_IDX_W-1:0] gate_idx(input logic [RP_IDX_W-1:0] idx,
                                                   input logic v);
    return v ? idx : '0;
  endfunction

  function automatic logic [RP_SRCS-1:0] valid_vec(input rp_src_t s);
    return {s.vd_v, s.vs1_v, s.vs2_v};
  endfunction

  function automatic logic [2:0] demand(input logic [RP_SRCS-1:0] v);
    return 3'(v[0]) + 3'(v[1]) + 3'(v[2]);
  endfunction

  // bit 0: port 1 wanted by both, bit 1: port 3 wanted by both
  function automatic logic [1:0] shared_clash(input logic [RP_SRCS-1:0] older,
                                              input logic [RP_SRCS-1:0] younger);
    return {older[2] & younger[1], older[1] & younger[2]};
  endfunction

endpackage

// File: rtl/vreg_rp_hazard.sv
module vreg_rp_hazard
  import vreg_rp_pkg::*;
(
  input  logic [RP_SRCS-1:0] old_vld,
  input  logic [RP_SRCS-1:0] yng_vld,
  output logic [1:0]         clash,
  output logic [3:0]         total_demand,
  output logic               hazard
);

  assign clash        = shared_clash(old_vld, yng_vld);
  assign total_demand = {1'b0, demand(old_vld)} + {1'b0, demand(yng_vld)};
  assign hazard       = |clash;

  always_comb begin
    if (total_demand > 4'd4) begin
      p_overdemand_r5: assert (hazard)
        else $error("more than four sources without hazard");
    end
    if (!(old_vld[1] | old_vld[2])) begin
      p_no_old_share_r4: assert (!hazard)
        else $error("hazard without older shared-port demand");
    end
    if (!(yng_vld[1] | yng_vld[2])) begin
      p_no_yng_share_r3: assert (!hazard)
        else $error("hazard without younger shared-port demand");
    end
  end

endmodule

// File: rtl/vreg_rp_portmap.sv
module vreg_rp_portmap
  import vreg_rp_pkg::*;
(
  input  rp_src_t                             old_src,
  input  rp_src_t                             yng_src,
  input  logic                                hazard,
  output logic [RP_PORTS-1:0][RP_IDX_W-1:0]   rd_idx
);

  logic yng_live;
  assign yng_live = ~hazard;

  always_comb begin
    rd_idx[0] = gate_idx(old_src.vs2, old_src.vs2_v);
    rd_idx[2] = gate_idx(yng_src.vs2, yng_src.vs2_v & yng_live);
    if (old_src.vs1_v)
      rd_idx[1] = old_src.vs1;
    else
      rd_idx[1] = gate_idx(yng_src.vd, yng_src.vd_v & yng_live);
    if (old_src.vd_v)
      rd_idx[3] = old_src.vd;
    else
      rd_idx[3] = gate_idx(yng_src.vs1, yng_src.vs1_v & yng_live);
  end

  always_comb begin
    if (hazard) begin
      p_port2_idle_r6: assert (rd_idx[2] == '0)
        else $error("port 2 busy during hazard");
      p_port3_older_r6: assert (rd_idx[3] == gate_idx(old_src.vd, old_src.vd_v))
        else $error("port 3 not owned by older slot during hazard");
    end
  end

endmodule

// File: rtl/vreg_rp_steer.sv
module vreg_rp_steer
  import vreg_rp_pkg::*;
#(
  parameter int unsigned DATA_W = 128
) (
  input  logic [RP_SLOTS-1:0][RP_SRCS-1:0]             vld,
  input  logic                                         hazard,
  input  logic [RP_PORTS-1:0][DATA_W-1:0]              rd_data,
  input  logic [DATA_W-1:0]                            v0_data,
  output logic [RP_SLOTS-1:0][RP_SRCS-1:0][DATA_W-1:0] opnd,
  output logic [RP_SLOTS-1:0][DATA_W-1:0]              mask
);

  for (genvar k = 0; k < RP_SLOTS; k++) begin : g_slot
    localparam int unsigned P_VS2 = 2 * k;
    localparam int unsigned P_VS1 = 2 * k + 1;
    localparam int unsigned P_VD  = (k == 0) ? 3 : 1;
    logic live;
    if (k == 0) begin : g_old
      assign live = 1'b1;
    end else begin : g_yng
      assign live = ~hazard;
    end
    assign opnd[k][0] = (vld[k][0] & live) ? rd_data[P_VS2] : '0;
    assign opnd[k][1] = (vld[k][1] & live) ? rd_data[P_VS1] : '0;
    assign opnd[k][2] = (vld[k][2] & live) ? rd_data[P_VD]  : '0;
    assign mask[k]    = v0_data;
  end

  always_comb begin
    if (hazard) begin
      p_yng_quiet_r8: assert (opnd[1] == '0)
        else $error("younger slot operands active during hazard");
    end
  end

endmodule

// File: rtl/vreg_read_alloc.sv
module vreg_read_alloc
  import vreg_rp_pkg::*;
#(
  parameter int unsigned IDX_W  = RP_IDX_W,
  parameter int unsigned DATA_W = 128
) (
  input  logic [IDX_W-1:0]                 u0_vs2_idx,
  input  logic                             u0_vs2_vld,
  input  logic [IDX_W-1:0]                 u0_vs1_idx,
  input  logic                             u0_vs1_vld,
  input  logic [IDX_W-1:0]                 u0_vd_idx,
  input  logic                             u0_vd_vld,
  input  logic [IDX_W-1:0]                 u1_vs2_idx,
  input  logic                             u1_vs2_vld,
  input  logic [IDX_W-1:0]                 u1_vs1_idx,
  input  logic                             u1_vs1_vld,
  input  logic [IDX_W-1:0]                 u1_vd_idx,
  input  logic                             u1_vd_vld,
  output logic [RP_PORTS-1:0][IDX_W-1:0]   rd_idx,
  input  logic [RP_PORTS-1:0][DATA_W-1:0]  rd_data,
  input  logic [DATA_W-1:0]                v0_data,
  output logic                             port_hazard,
  output logic [DATA_W-1:0]                u0_vs2_opnd,
  output logic [DATA_W-1:0]                u0_vs1_opnd,
  output logic [DATA_W-1:0]                u0_vd_opnd,
  output logic [DATA_W-1:0]                u0_mask_opnd,
  output logic [DATA_W-1:0]                u1_vs2_opnd,
  output logic [DATA_W-1:0]                u1_vs1_opnd,
  output logic [DATA_W-1:0]                u1_vd_opnd,
  output logic [DATA_W-1:0]                u1_mask_opnd
);

  rp_src_t old_src, yng_src;
  logic [RP_SLOTS-1:0][RP_SRCS-1:0]             slot_vld;
  logic [1:0]                                   clash;
  logic [3:0]                                   total_demand;
  logic [RP_SLOTS-1:0][RP_SRCS-1:0][DATA_W-1:0] opnd;
  logic [RP_SLOTS-1:0][DATA_W-1:0]              mask;

  assign old_src = '{vs2: u0_vs2_idx, vs2_v: u0_vs2_vld,
                     vs1: u0_vs1_idx, vs1_v: u0_vs1_vld,
                     vd:  u0_vd_idx,  vd_v:  u0_vd_vld};
  assign yng_src = '{vs2: u1_vs2_idx, vs2_v: u1_vs2_vld,
                     vs1: u1_vs1_idx, vs1_v: u1_vs1_vld,
                     vd:  u1_vd_idx,  vd_v:  u1_vd_vld};
  assign slot_vld[0] = valid_vec(old_src);
  assign slot_vld[1] = valid_vec(yng_src);

  vreg_rp_hazard u_hazard (
    .old_vld      (slot_vld[0]),
    .yng_vld      (slot_vld[1]),
    .clash        (clash),
    .total_demand (total_demand),
    .hazard       (port_hazard)
  );

  vreg_rp_portmap u_portmap (
    .old_src (old_src),
    .yng_src (yng_src),
    .hazard  (port_hazard),
    .rd_idx  (rd_idx)
  );

  vreg_rp_steer #(.DATA_W(DATA_W)) u_steer (
    .vld     (slot_vld),
    .hazard  (port_hazard),
    .rd_data (rd_data),
    .v0_data (v0_data),
    .opnd    (opnd),
    .mask    (mask)
  );

  assign u0_vs2_opnd  = opnd[0][0];
  assign u0_vs1_opnd  = opnd[0][1];
  assign u0_vd_opnd   = opnd[0][2];
  assign u0_mask_opnd = mask[0];
  assign u1_vs2_opnd  = opnd[1][0];
  assign u1_vs1_opnd  = opnd[1][1];
  assign u1_vd_opnd   = opnd[1][2];
  assign u1_mask_opnd = mask[1];

  always_comb begin
    if (!port_hazard) begin
      p_old_map_r1: assert (rd_idx[0] == gate_idx(u0_vs2_idx, u0_vs2_vld)
                            && (!u0_vs1_vld || rd_idx[1] == u0_vs1_idx)
                            && (!u0_vd_vld  || rd_idx[3] == u0_vd_idx))
        else $error("older slot index mapping broken");
      p_yng_map_r2: assert ((!u1_vs2_vld || rd_idx[2] == u1_vs2_idx)
                            && (!u1_vs1_vld || rd_idx[3] == u1_vs1_idx)
                            && (!u1_vd_vld  || rd_idx[1] == u1_vd_idx))
        else $error("younger slot index mapping broken");
    end
    if (!(u0_vs1_vld | u1_vd_vld)) begin
      p_port1_free_r3: assert (rd_idx[1] == '0)
        else $error("unclaimed port 1 not zero");
    end
    p_mask_path_r9: assert (u0_mask_opnd == v0_data && u1_mask_opnd == v0_data)
      else $error("mask operand not from dedicated path");
    p_clash_flag_r4: assert (port_hazard == (clash != 2'b00))
      else $error("hazard flag disagrees with port clash");
  end

endmodule

// File: tb/vreg_read_alloc_test.sv
module vreg_read_alloc_test;
  localparam int CLK_PERIOD = 10;
  localparam int IW = 5;
  localparam int DW = 128;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic [IW-1:0] a_vs2, a_vs1, a_vd, b_vs2, b_vs1, b_vd;
  logic a_vs2_v, a_vs1_v, a_vd_v, b_vs2_v, b_vs1_v, b_vd_v;
  logic [3:0][IW-1:0] rd_idx;
  logic [3:0][DW-1:0] rd_data;
  logic [DW-1:0] v0_data;
  logic hz;
  logic [DW-1:0] o0_vs2, o0_vs1, o0_vd, o0_m, o1_vs2, o1_vs1, o1_vd, o1_m;

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 0;

  vreg_read_alloc #(.IDX_W(IW), .DATA_W(DW)) uut (
    .u0_vs2_idx(a_vs2), .u0_vs2_vld(a_vs2_v), .u0_vs1_idx(a_vs1), .u0_vs1_vld(a_vs1_v),
    .u0_vd_idx(a_vd), .u0_vd_vld(a_vd_v),
    .u1_vs2_idx(b_vs2), .u1_vs2_vld(b_vs2_v), .u1_vs1_idx(b_vs1), .u1_vs1_vld(b_vs1_v),
    .u1_vd_idx(b_vd), .u1_vd_vld(b_vd_v),
    .rd_idx(rd_idx), .rd_data(rd_data), .v0_data(v0_data), .port_hazard(hz),
    .u0_vs2_opnd(o0_vs2), .u0_vs1_opnd(o0_vs1), .u0_vd_opnd(o0_vd), .u0_mask_opnd(o0_m),
    .u1_vs2_opnd(o1_vs2), .u1_vs1_opnd(o1_vs1), .u1_vd_opnd(o1_vd), .u1_mask_opnd(o1_m)
  );

  task automatic chk(input string req, input string what, input logic [DW-1:0] act,
                     input logic [DW-1:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic set_valid(input logic [5:0] m);
    {b_vd_v, b_vs1_v, b_vs2_v, a_vd_v, a_vs1_v, a_vs2_v} = m;
  endtask

  task automatic fill_data(input logic [7:0] seed);
    for (int p = 0; p < 4; p++) rd_data[p] = {(DW/8){8'(seed + 8'(17 * (p + 1)))}};
    v0_data = {(DW/8){seed ^ 8'h5A}};
  endtask

  // idle state: nothing valid, every output quiet
  task automatic t_idle();
    set_valid(6'd0);
    a_vs2 = 5'd9; a_vs1 = 5'd10; a_vd = 5'd11; b_vs2 = 5'd12; b_vs1 = 5'd13; b_vd = 5'd14;
    fill_data(8'h01);
    #1;
    chk("R3", "idle rd_idx", DW'(rd_idx), '0);
    chk("R4", "idle hazard", DW'(hz), '0);
    chk("R7", "idle u0 vs2", o0_vs2, '0);
    chk("R8", "idle u1 vd", o1_vd, '0);
  endtask

  // all 64 valid combinations against the fixed port layout
  task automatic t_sweep();
    a_vs2 = 5'd3; a_vs1 = 5'd7; a_vd = 5'd11; b_vs2 = 5'd19; b_vs1 = 5'd23; b_vd = 5'd29;
    fill_data(8'h20);
    for (int m = 0; m < 64; m++) begin
      logic [5:0] b;
      logic e_hz;
      logic [IW-1:0] e0, e1, e2, e3;
      b = 6'(m);
      set_valid(b);
      #1;
      e_hz = (b[1] & b[5]) | (b[2] & b[4]);
      e0 = b[0] ? 5'd3 : 5'd0;
      e1 = b[1] ? 5'd7 : ((!e_hz && b[5]) ? 5'd29 : 5'd0);
      e2 = (!e_hz && b[3]) ? 5'd19 : 5'd0;
      e3 = b[2] ? 5'd11 : ((!e_hz && b[4]) ? 5'd23 : 5'd0);
      chk("R4", "hazard", DW'(hz), DW'(e_hz));
      if ($countones(b) > 4) chk("R5", "overdemand hazard", DW'(hz), DW'(1));
      chk(e_hz ? "R6" : "R1", "port0", DW'(rd_idx[0]), DW'(e0));
      chk(e_hz ? "R6" : "R3", "port1", DW'(rd_idx[1]), DW'(e1));
      chk(e_hz ? "R6" : "R2", "port2", DW'(rd_idx[2]), DW'(e2));
      chk(e_hz ? "R6" : "R3", "port3", DW'(rd_idx[3]), DW'(e3));
      chk("R7", "u0 vs2", o0_vs2, b[0] ? rd_data[0] : '0);
      chk("R7", "u0 vs1", o0_vs1, b[1] ? rd_data[1] : '0);
      chk("R7", "u0 vd", o0_vd, b[2] ? rd_data[3] : '0);
      chk("R8", "u1 vs2", o1_vs2, (b[3] && !e_hz) ? rd_data[2] : '0);
      chk("R8", "u1 vs1", o1_vs1, (b[4] && !e_hz) ? rd_data[3] : '0);
      chk("R8", "u1 vd", o1_vd, (b[5] && !e_hz) ? rd_data[1] : '0);
      chk("R9", "masks", o0_m ^ o1_m ^ v0_data, v0_data);
    end
  endtask

  // index values pass through unchanged on every non-conflicting port
  task automatic t_indices();
    set_valid(6'b011_011);
    fill_data(8'h40);
    for (int v = 0; v < 32; v++) begin
      a_vs2 = 5'(v); a_vs1 = 5'(v + 5); b_vs2 = 5'(v + 11); b_vs1 = 5'(v + 23);
      a_vd = 5'(v + 1); b_vd = 5'(v + 2);
      #1;
      chk("R1", "u0 vs2 index", DW'(rd_idx[0]), DW'(a_vs2));
      chk("R1", "u0 vs1 index", DW'(rd_idx[1]), DW'(a_vs1));
      chk("R2", "u1 vs2 index", DW'(rd_idx[2]), DW'(b_vs2));
      chk("R2", "u1 vs1 index", DW'(rd_idx[3]), DW'(b_vs1));
    end
  endtask

  // hazard with slot 0 fully valid: slot 0 owns ports, mask still shared
  task automatic t_hazard_owner();
    a_vs2 = 5'd1; a_vs1 = 5'd2; a_vd = 5'd4; b_vs2 = 5'd8; b_vs1 = 5'd16; b_vd = 5'd31;
    set_valid(6'b111_111);
    fill_data(8'h77);
    #1;
    chk("R6", "hazard all", {rd_idx, 8'(hz)}, {5'd4, 5'd0, 5'd2, 5'd1, 8'd1});
    chk("R9", "u1 mask in hazard", o1_m, v0_data);
    chk("R8", "u1 vs1 in hazard", o1_vs1, '0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_idle();
    t_sweep();
    t_indices();
    t_hazard_owner();
    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule